// File: doc/BRIEF.md
# Single-Bus Datapath Step Sequencer

This block is a minimal processor datapath in which every register transfer travels over one shared internal bus. It holds a program counter, a memory address latch, a memory data latch, an instruction latch, two general registers, an ALU operand latch (Y) and an ALU result latch (Z). A hardwired step counter drives bus source selection and register loads one transfer per step. It fetches one instruction and, when that instruction is a register-to-register add, executes it and writes the sum back to the first operand register.

Instruction fetch computes the next program counter by adding a constant 4 while the fetch address goes out. The step counter then stalls until external memory reports that the requested word is ready. Any opcode other than the add opcode is flagged as illegal once the instruction word has been loaded, and the sequencer returns straight to fetch. The register contents, the program counter and the current step are visible at the ports for observation.

Top module: `single_bus_core`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `pc` to 0, `step` to 1, `mem_rd` and `illegal` to 0, and `gpr0`/`gpr1` to the values of the parameters `GPR0_RST`/`GPR1_RST`.
- R2: Step 1 lasts exactly one cycle. After it, `mem_addr` equals the value `pc` had in step 1, `mem_rd` is 1 and `step` is 2.
- R3: When step 3 is reached, `pc` equals `mem_addr` + 4 modulo 2^32.
- R4: In step 2 the counter holds and `mem_rd` stays 1 until a cycle with `mem_ready` high. That cycle latches `mem_rdata`, drops `mem_rd` and moves to step 3.
- R5: `mem_ready` while no read is outstanding (`mem_rd` low) has no effect on the step sequence, the registers or the fetched instruction.
- R6: Instruction decode uses only bits [31:24] as opcode (add is 8'h01 by default), bit [1] as destination/first-operand select and bit [0] as second-operand select, with 0 meaning `gpr0` and 1 meaning `gpr1`. All other bits are ignored.
- R7: An add instruction writes the destination register with destination + source modulo 2^32. The new value is visible once `step` is back at 1.
- R8: An add with both selects equal doubles that register modulo 2^32.
- R9: For a non-add opcode, `illegal` is 1 for exactly the one cycle after step 3, `step` is 1 in that cycle, and neither general register changes.
- R10: Exactly one source drives the internal bus in every step.
- R11: An add instruction spends 5 + N cycles from step 1 to the next step 1, and an illegal one spends 2 + N cycles, where N (at least 1) is the number of cycles spent in step 2. Step 6 is always followed by step 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Memory reports the read word is valid |
| mem_rdata | input | 32 | Word returned by memory |
| mem_addr | output | 32 | Read address, held in the address latch |
| mem_rd | output | 1 | Read request, held until accepted |
| pc | output | 32 | Program counter |
| gpr0 | output | 32 | General register 0 |
| gpr1 | output | 32 | General register 1 |
| step | output | 3 | Current control step, 1 to 6 |
| illegal | output | 1 | One-cycle pulse for a non-add opcode |

## Verification
Two events can fall in the same cycle: the stall release in step 2 and the loads of PC and Y from Z that step 2 performs on every cycle it lasts. A second pair is a spurious ready arriving while the counter walks through steps 1, 3, 4 or 5. The bench provokes the first pair with memory latencies from zero to three cycles, so the word sometimes returns in the very first wait cycle. It provokes the second by raising `mem_ready` at random whenever no read is outstanding. It judges the outcome by the post-fetch program counter, the per-instruction cycle count against 5 + N or 2 + N, and the register values computed by a bench model.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd2,
    ST_LDIR  = 3'd3,
    ST_OPA   = 3'd4,
    ST_OPB   = 3'd5,
    ST_WB    = 3'd6
  } step_e;

  localparam int NSRC    = 4;
  localparam int SRC_PC  = 0;
  localparam int SRC_Z   = 1;
  localparam int SRC_MDR = 2;
  localparam int SRC_GPR = 3;

  typedef struct packed {
    logic [NSRC-1:0] bus_oh;
    logic            gpr_sel;
    logic            ld_mar;
    logic            ld_pc;
    logic            ld_y;
    logic            ld_z;
    logic            ld_ir;
    logic            ld_mdr;
    logic            ld_gpr;
    logic            a_from_y;
    logic            rd_start;
    logic            wmfc;
    logic            fin;
  } ctl_t;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int DW      = 32,
  parameter int CONST_A = 4
) (
  input  logic          a_from_y,
  input  logic [DW-1:0] y_val,
  input  logic [DW-1:0] b_val,
  output logic [DW-1:0] sum
);
  localparam logic [DW-1:0] KA = DW'(CONST_A);

  logic [DW-1:0] a_val;

  always_comb begin
    a_val = a_from_y ? y_val : KA;
    sum   = a_val + b_val;
  end

endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int          OPW    = 8,
  parameter logic [7:0]  ADD_OP = 8'h01
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mem_ready,
  input  logic [OPW-1:0] bus_op,
  input  logic           ir_dst,
  input  logic           ir_src,
  output ctl_t           ctl,
  output step_e          step_q,
  output logic           rd_pend_q,
  output logic           illegal_q
);
  localparam logic [OPW-1:0] OP_ADD = OPW'(ADD_OP);

  step_e step_d;
  logic  accept;
  logic  legal_op;

  assign accept   = (step_q == ST_WAIT) && rd_pend_q && mem_ready;
  assign legal_op = (bus_op == OP_ADD);

  always_comb begin
    ctl        = '0;
    ctl.bus_oh = NSRC'(1) << SRC_PC;
    step_d     = step_q;
    case (step_q)
      ST_FETCH: begin
        ctl.bus_oh   = NSRC'(1) << SRC_PC;
        ctl.ld_mar   = 1'b1;
        ctl.rd_start = 1'b1;
        ctl.ld_z     = 1'b1;
        step_d       = ST_WAIT;
      end
      ST_WAIT: begin
        ctl.bus_oh = NSRC'(1) << SRC_Z;
        ctl.ld_pc  = 1'b1;
        ctl.ld_y   = 1'b1;
        ctl.wmfc   = 1'b1;
        ctl.ld_mdr = accept;
        if (accept) step_d = ST_LDIR;
      end
      ST_LDIR: begin
        ctl.bus_oh = NSRC'(1) << SRC_MDR;
        ctl.ld_ir  = 1'b1;
        step_d     = legal_op ? ST_OPA : ST_FETCH;
      end
      ST_OPA: begin
        ctl.bus_oh   = NSRC'(1) << SRC_GPR;
        ctl.gpr_sel  = ir_dst;
        ctl.ld_y     = 1'b1;
        ctl.a_from_y = 1'b1;
        step_d       = ST_OPB;
      end
      ST_OPB: begin
        ctl.bus_oh   = NSRC'(1) << SRC_GPR;
        ctl.gpr_sel  = ir_src;
        ctl.a_from_y = 1'b1;
        ctl.ld_z     = 1'b1;
        step_d       = ST_WB;
      end
      ST_WB: begin
        ctl.bus_oh  = NSRC'(1) << SRC_Z;
        ctl.gpr_sel = ir_dst;
        ctl.ld_gpr  = 1'b1;
        ctl.fin     = 1'b1;
        step_d      = ST_FETCH;
      end
      default: step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= ST_FETCH;
      rd_pend_q <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      step_q    <= step_d;
      illegal_q <= (step_q == ST_LDIR) && !legal_op;
      if (ctl.rd_start)  rd_pend_q <= 1'b1;
      else if (accept)   rd_pend_q <= 1'b0;
    end
  end

  AST_FETCH_ONE: assert property (@(posedge clk) disable iff (rst)
    step_q == ST_FETCH |=> step_q == ST_WAIT && rd_pend_q);  // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    step_q == ST_WAIT && !mem_ready |=> step_q == ST_WAIT);  // R4
  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
    rd_pend_q && !mem_ready |=> rd_pend_q);  // R4
  AST_SPUR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    step_q == ST_OPA |=> step_q == ST_OPB);  // R5
  AST_ILL_FETCH: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> step_q == ST_FETCH);  // R9
  AST_ILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    illegal_q |=> !illegal_q);  // R9
  AST_BUS_ONE: assert property (@(posedge clk) disable iff (rst)
    $countones(ctl.bus_oh) == 1);  // R10
  AST_END_FETCH: assert property (@(posedge clk) disable iff (rst)
    step_q == ST_WB |=> step_q == ST_FETCH);  // R11

endmodule

// File: rtl/sbus_dpath.sv
module sbus_dpath
  import sbus_pkg::*;
#(
  parameter int              DW      = 32,
  parameter int              NGPR    = 2,
  parameter int              CONST_A = 4,
  parameter logic [DW-1:0]   PC_RST  = '0,
  parameter logic [NGPR*DW-1:0] GPR_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] bus,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] gpr_q [NGPR]
);
  localparam int GSW = (NGPR > 1) ? $clog2(NGPR) : 1;

  logic [DW-1:0]  mdr_q, y_q, z_q, alu_sum, gpr_bus;
  logic [GSW-1:0] gidx;

  assign gidx    = GSW'(ctl.gpr_sel);
  assign gpr_bus = gpr_q[gidx];

  always_comb begin
    bus = '0;
    if (ctl.bus_oh[SRC_PC])  bus = bus | pc_q;
    if (ctl.bus_oh[SRC_Z])   bus = bus | z_q;
    if (ctl.bus_oh[SRC_MDR]) bus = bus | mdr_q;
    if (ctl.bus_oh[SRC_GPR]) bus = bus | gpr_bus;
  end

  sbus_alu #(.DW(DW), .CONST_A(CONST_A)) u_alu (
    .a_from_y (ctl.a_from_y),
    .y_val    (y_q),
    .b_val    (bus),
    .sum      (alu_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= PC_RST;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      if (ctl.ld_pc)  pc_q  <= bus;
      if (ctl.ld_mar) mar_q <= bus;
      if (ctl.ld_mdr) mdr_q <= mem_rdata;
      if (ctl.ld_ir)  ir_q  <= bus;
      if (ctl.ld_y)   y_q   <= bus;
      if (ctl.ld_z)   z_q   <= alu_sum;
    end
  end

  for (genvar g = 0; g < NGPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)                                  gpr_q[g] <= GPR_RST[g*DW +: DW];
      else if (ctl.ld_gpr && gidx == GSW'(g))   gpr_q[g] <= bus;
    end
  end

  AST_PC_NEXT: assert property (@(posedge clk) disable iff (rst)
    ctl.ld_ir |-> pc_q == mar_q + DW'(CONST_A));  // R3
  AST_GPR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctl.ld_gpr |=> gpr_q[0] == $past(gpr_q[0]));  // R9

endmodule

// File: rtl/single_bus_core.sv
module single_bus_core
  import sbus_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          OPW      = 8,
  parameter logic [7:0]  ADD_OP   = 8'h01,
  parameter int          CONST_A  = 4,
  parameter logic [31:0] GPR0_RST = 32'h8000_0003,
  parameter logic [31:0] GPR1_RST = 32'h7FFF_FFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] gpr0,
  output logic [DW-1:0] gpr1,
  output logic [2:0]    step,
  output logic          illegal
);
  localparam int NGPR = 2;

  ctl_t          ctl;
  step_e         step_q;
  logic [DW-1:0] bus, ir_q;
  logic [DW-1:0] gpr_q [NGPR];

  sbus_ctrl #(.OPW(OPW), .ADD_OP(ADD_OP)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mem_ready (mem_ready),
    .bus_op    (bus[DW-1 -: OPW]),
    .ir_dst    (ir_q[1]),
    .ir_src    (ir_q[0]),
    .ctl       (ctl),
    .step_q    (step_q),
    .rd_pend_q (mem_rd),
    .illegal_q (illegal)
  );

  sbus_dpath #(
    .DW      (DW),
    .NGPR    (NGPR),
    .CONST_A (CONST_A),
    .PC_RST  ('0),
    .GPR_RST ({DW'(GPR1_RST), DW'(GPR0_RST)})
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .bus       (bus),
    .pc_q      (pc),
    .mar_q     (mem_addr),
    .ir_q      (ir_q),
    .gpr_q     (gpr_q)
  );

  assign gpr0 = gpr_q[0];
  assign gpr1 = gpr_q[1];
  assign step = step_q;

  AST_WB_SUM: assert property (@(posedge clk) disable iff (rst)
    step_q == ST_WB && ir_q[1:0] == 2'b00 |=> gpr0 == $past(bus));  // R7

endmodule

// File: tb/single_bus_core_tb.sv
module single_bus_core_tb;
  localparam logic [31:0] R0_INIT = 32'h8000_0003;
  localparam logic [31:0] R1_INIT = 32'h7FFF_FFFE;
  localparam int          N_INSTR = 300;
  localparam int          WDOG    = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr, pc, gpr0, gpr1;
  logic        mem_rd, illegal;
  logic [2:0]  step;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  single_bus_core u_dut (
    .clk(clk), .rst(rst), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .pc(pc), .gpr0(gpr0),
    .gpr1(gpr1), .step(step), .illegal(illegal)
  );

  logic [31:0] prog [0:63];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_add(input bit dst, input bit src,
                                         input logic [21:0] junk);
    return {8'h01, junk, dst, src};
  endfunction

  function automatic logic [31:0] mk_bad(input logic [7:0] op);
    return {(op == 8'h01) ? 8'h02 : op, 24'h00_0003};
  endfunction

  initial begin
    logic [31:0] eg [2];
    logic [31:0] exp_pc, cur;
    logic [2:0]  prev_s;
    bit          cur_legal, spur, done_wd;
    int          ins_cyc, n_s2, lat, ndone, cyc;
    int unsigned seed;
    seed = $urandom(32'd2024);

    prog[0] = mk_add(1'b0, 1'b1, 22'h0);        // R7 g0 += g1
    prog[1] = mk_add(1'b1, 1'b0, 22'h3F_FFFF);  // R6 junk bits ignored
    prog[2] = mk_add(1'b0, 1'b0, 22'h0);        // R8 double g0
    prog[3] = mk_add(1'b1, 1'b1, 22'h15_5555);  // R8 double g1
    prog[4] = mk_bad(8'h00);                    // R9
    prog[5] = mk_bad(8'hFF);                    // R9
    prog[6] = mk_bad(8'h81);                    // R9
    prog[7] = mk_add(1'b1, 1'b0, 22'h0);
    for (int i = 8; i < 64; i++) begin
      if ($urandom % 5 != 0)
        prog[i] = mk_add(1'($urandom), 1'($urandom), 22'($urandom));
      else
        prog[i] = mk_bad(8'($urandom));
    end

    rst = 1'b1; mem_ready = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(step == 3'd1, "R1 step", 32'(step), 32'd1);
    chk(pc == 32'd0, "R1 pc", pc, 32'd0);
    chk(mem_rd == 1'b0, "R1 mem_rd", 32'(mem_rd), 32'd0);
    chk(illegal == 1'b0, "R1 illegal", 32'(illegal), 32'd0);
    chk(gpr0 == R0_INIT, "R1 gpr0", gpr0, R0_INIT);
    chk(gpr1 == R1_INIT, "R1 gpr1", gpr1, R1_INIT);
    rst = 1'b0;

    eg[0] = R0_INIT; eg[1] = R1_INIT;
    exp_pc = '0; cur = '0; cur_legal = 1'b0;
    prev_s = 3'd1; spur = 1'b0; ins_cyc = 1; n_s2 = 0; lat = 0;
    ndone = 0; cyc = 0; done_wd = 1'b0;

    while (ndone < N_INSTR) begin
      @(negedge clk);
      cyc++;
      if (cyc > WDOG) begin done_wd = 1'b1; break; end

      // observe
      if (step == 3'd2 && prev_s == 3'd1) begin
        chk(mem_addr == exp_pc, "R2 fetch address", mem_addr, exp_pc);
        chk(mem_rd == 1'b1, "R2 read request", 32'(mem_rd), 32'd1);
      end
      if (step == 3'd2) begin
        n_s2++;
        chk(mem_rd == 1'b1, "R4 request held while stalled", 32'(mem_rd), 32'd1);
      end
      if (spur && (prev_s == 3'd1 || prev_s == 3'd4 || prev_s == 3'd5))
        chk(step == prev_s + 3'd1, "R5 spurious ready ignored",
            32'(step), 32'(prev_s + 3'd1));
      if (step == 3'd3 && prev_s == 3'd2) begin
        chk(pc == exp_pc + 32'd4, "R3 pc advance", pc, exp_pc + 32'd4);
        cur = prog[exp_pc[7:2]];
        exp_pc = exp_pc + 32'd4;
        cur_legal = (cur[31:24] == 8'h01);
        if (cur_legal) eg[cur[1]] = eg[cur[1]] + eg[cur[0]];
      end
      if (step == 3'd1 && (prev_s == 3'd3 || prev_s == 3'd6)) begin
        if (cur_legal) begin
          chk(prev_s == 3'd6, "R6 add decoded", 32'(prev_s), 32'd6);
          chk(ins_cyc == 5 + n_s2, "R11 add cycles", 32'(ins_cyc), 32'(5 + n_s2));
        end else begin
          chk(prev_s == 3'd3, "R9 illegal returns to fetch", 32'(prev_s), 32'd3);
          chk(ins_cyc == 2 + n_s2, "R11 illegal cycles", 32'(ins_cyc), 32'(2 + n_s2));
        end
        chk(illegal == !cur_legal, "R9 illegal flag", 32'(illegal), 32'(!cur_legal));
        chk(gpr0 == eg[0], "R7/R8/R10 gpr0", gpr0, eg[0]);
        chk(gpr1 == eg[1], "R7/R8/R10 gpr1", gpr1, eg[1]);
        ins_cyc = 1; n_s2 = 0; ndone++;
      end else begin
        ins_cyc++;
        if (illegal)
          chk(1'b0, "R9 stray illegal pulse", 32'(illegal), 32'd0);
      end
      prev_s = step;

      // drive
      spur = 1'b0;
      if (mem_rd) begin
        if (lat == 0) begin
          mem_ready = 1'b1;
          mem_rdata = prog[mem_addr[7:2]];
          lat = (ndone < 8) ? 0 : int'($urandom % 4);
        end else begin
          mem_ready = 1'b0;
          mem_rdata = $urandom;
          lat--;
        end
      end else begin
        spur = ($urandom % 4 == 0);
        mem_ready = spur;
        mem_rdata = $urandom;
      end
    end

    if (done_wd) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", ndone, N_INSTR);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule